// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide host interface of one legacy PC-style programmable interrupt controller. It has two addresses, selected by `addr`. With `addr`=0 the write goes to the command port and with `addr`=1 it goes to the data port. The block follows the four-step initialization sequence and then decodes the run-time operation commands. It keeps the configuration state that a separate priority resolver needs and drives that state out as plain outputs: the interrupt mask, vector base, special-mask flag, auto-EOI flag, special fully-nested flag, the rotation flag and the lowest-priority level.

The request and service registers live outside this block, and so does the winner of the priority race. They arrive as inputs and are only multiplexed onto the read bus. A read taken while a poll is armed works as an acknowledge. It returns the winning pin with bit 7 set, and in the same cycle it pulses `ack_stb` so the resolver can accept that pin. End-of-interrupt commands are passed to the resolver as a one-cycle strobe that carries their specific flag and level.

The parameter `IS_MASTER` selects a master instance or a cascaded slave instance. Only a master instance may enter special fully-nested mode.

Top module: `pic_cmd_seq`

## Requirements
- R1: After synchronous reset `rst`, `ready`=0, `init_err`=0, `mask`=0, `vec_base`=0, `lowprio`=0 and every mode flag is 0. `rdata` then returns `irr` on the command port.
- R2: A command-port write with data bit 4 set is the first initialization word (ICW1). It sets `mask` to 0 and `lowprio` to 7, selects the request register for reads, clears the poll and special-mask flags, and drops `ready`.
- R3: If ICW1 has bit 1 set (single mode) or bit 0 clear (no fourth word), `init_err` goes to 1 and `ready` stays 0. The sequence does not advance, so the next data-port write loads `mask`. A valid ICW1 clears `init_err`.
- R4: After a valid ICW1, the data-port writes are taken in order as ICW2, ICW3 and ICW4. ICW2 loads `vec_base` with data AND 0xF8. ICW3 changes no output.
- R5: If ICW4 has bit 0 clear (8086 mode missing), `init_err` goes to 1 and `ready` stays 0. The sequence keeps waiting for ICW4.
- R6: A valid ICW4 loads `aeoi` from bit 1 and sets `sfnm` to bit 4 only when `IS_MASTER`=1 (a slave instance keeps 0). It sets `ready` and returns the sequence to idle.
- R7: Outside the ICW2 to ICW4 steps, a data-port write loads the 8-bit `mask`.
- R8: While ready, a command-port write with bit 4 clear and bit 3 set is OCW3. If bit 6 is set, bit 5 loads `smm`. If bit 1 is set, bit 0 selects the service register (1) or the request register (0) for reads, and bit 2 loads `poll_armed`.
- R9: While ready, a command-port write with bits 4 and 3 clear is OCW2. Bit 7 loads `rotate`. If bit 5 is set, `eoi_stb` is high for the one cycle after the write, with `eoi_spec` = bit 6 and `eoi_lvl` = bits 2:0. If bit 6 is set and the new rotate is 1, `lowprio` loads bits 2:0.
- R10: When no poll is armed, a data-port read returns `mask`. A command-port read returns `isr` if the service register is selected, and `irr` otherwise.
- R11: A read with a poll armed clears the poll. If `best_valid`=1 it returns 0x80 OR `best_pin` and pulses `ack_stb` in the same cycle with `ack_pin`=`best_pin`. Otherwise it returns 0x00 and acknowledges nothing.
- R12: While not ready, a command-port write with bit 4 clear has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irr | input | 8 | Request register from the resolver |
| isr | input | 8 | Service register from the resolver |
| best_valid | input | 1 | An eligible request exists |
| best_pin | input | 3 | Highest-priority eligible pin |
| ack_stb | output | 1 | Poll-read acknowledge of `ack_pin` |
| ack_pin | output | 3 | Acknowledged pin |
| eoi_stb | output | 1 | End-of-interrupt command pulse |
| eoi_spec | output | 1 | EOI names a specific level |
| eoi_lvl | output | 3 | Level named by OCW2 |
| ready | output | 1 | Initialization complete |
| init_err | output | 1 | Last initialization word was rejected |
| mask | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low 3 bits zero |
| lowprio | output | 3 | Lowest-priority level |
| rotate | output | 1 | Rotation enabled by the last OCW2 |
| sel_isr | output | 1 | Command-port reads return the service register |
| poll_armed | output | 1 | Next read is a poll |
| smm | output | 1 | Special mask mode |
| aeoi | output | 1 | Automatic end of interrupt |
| sfnm | output | 1 | Special fully-nested mode |

## Verification
The bench targets four corner cases:
- ICW1 words that are rejected. A design that advanced the sequence after one of them would take the following data byte as a vector base and leave the mask unchanged.
- A rejected ICW4. A design that fell back to idle after it would load the repeated ICW4 into the mask and never become ready.
- Command writes that arrive before the controller is ready. A design that decoded them would change `smm` or the read selection, or would pulse `eoi_stb`.
- Poll reads, with and without an eligible pin, including an OCW3 that sets the poll bit without the read-register bit. A design that got these wrong would leave the poll armed, acknowledge a pin when none exists, or arm the poll by mistake.

Random interleaving of writes and reads against a bench model covers the way the data port's meaning changes with the sequence step.

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq #(
  parameter bit IS_MASTER = 1'b1,
  parameter int DW = 8,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] irr,
  input  logic [DW-1:0] isr,
  input  logic          best_valid,
  input  logic [LW-1:0] best_pin,
  output logic          ack_stb,
  output logic [LW-1:0] ack_pin,
  output logic          eoi_stb,
  output logic          eoi_spec,
  output logic [LW-1:0] eoi_lvl,
  output logic          ready,
  output logic          init_err,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic [LW-1:0] lowprio,
  output logic          rotate,
  output logic          sel_isr,
  output logic          poll_armed,
  output logic          smm,
  output logic          aeoi,
  output logic          sfnm
);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_W2   = 2'd1;
  localparam logic [1:0] ST_W3   = 2'd2;
  localparam logic [1:0] ST_W4   = 2'd3;
  localparam logic [DW-1:0] BASE_KEEP = {{(DW-LW){1'b1}}, {LW{1'b0}}};

  logic [1:0] step;

  wire cmd_wr   = wr_en & ~addr;
  wire dat_wr   = wr_en & addr;
  wire is_icw1  = cmd_wr & wdata[4];
  wire icw1_bad = wdata[1] | ~wdata[0];
  wire is_ocw3  = cmd_wr & ~wdata[4] & ready & wdata[3];
  wire is_ocw2  = cmd_wr & ~wdata[4] & ready & ~wdata[3];

  wire [DW-1:0] poll_word = best_valid ? {1'b1, {(DW-1-LW){1'b0}}, best_pin} : '0;

  assign rdata   = poll_armed ? poll_word : (addr ? mask : (sel_isr ? isr : irr));
  assign ack_stb = rd_en & poll_armed & best_valid;
  assign ack_pin = best_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= ST_IDLE;
      ready      <= 1'b0;
      init_err   <= 1'b0;
      mask       <= '0;
      vec_base   <= '0;
      lowprio    <= '0;
      rotate     <= 1'b0;
      sel_isr    <= 1'b0;
      poll_armed <= 1'b0;
      smm        <= 1'b0;
      aeoi       <= 1'b0;
      sfnm       <= 1'b0;
      eoi_stb    <= 1'b0;
      eoi_spec   <= 1'b0;
      eoi_lvl    <= '0;
    end else begin
      eoi_stb <= 1'b0;
      if (rd_en && poll_armed)
        poll_armed <= 1'b0;
      if (is_icw1) begin
        ready      <= 1'b0;
        mask       <= '0;
        lowprio    <= '1;
        sel_isr    <= 1'b0;
        poll_armed <= 1'b0;
        smm        <= 1'b0;
        init_err   <= icw1_bad;
        step       <= icw1_bad ? ST_IDLE : ST_W2;
      end else if (dat_wr) begin
        case (step)
          ST_W2: begin
            vec_base <= wdata & BASE_KEEP;
            step     <= ST_W3;
          end
          ST_W3: step <= ST_W4;
          ST_W4: begin
            if (!wdata[0]) begin
              init_err <= 1'b1;
            end else begin
              init_err <= 1'b0;
              aeoi     <= wdata[1];
              sfnm     <= IS_MASTER & wdata[4];
              ready    <= 1'b1;
              step     <= ST_IDLE;
            end
          end
          default: mask <= wdata;
        endcase
      end else if (is_ocw3) begin
        if (wdata[6])
          smm <= wdata[5];
        if (wdata[1]) begin
          sel_isr    <= wdata[0];
          poll_armed <= wdata[2];
        end
      end else if (is_ocw2) begin
        rotate <= wdata[7];
        if (wdata[5]) begin
          eoi_stb  <= 1'b1;
          eoi_spec <= wdata[6];
          eoi_lvl  <= wdata[LW-1:0];
        end
        if (wdata[6] && wdata[7])
          lowprio <= wdata[LW-1:0];
      end
    end
  end

  p_icw1_defaults_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (mask == '0 && lowprio == '1 && !ready && !poll_armed && !smm && !sel_isr));

  p_icw1_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4] && (wdata[1] || !wdata[0])) |=> (init_err && !ready));

  p_ready_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(wr_en && addr && wdata[0]));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && step == ST_IDLE) |=> (mask == $past(wdata)));

  p_eoi_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    eoi_stb |=> !eoi_stb || $past(wr_en && !addr && ready));

  p_poll_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_armed && !wr_en) |=> !poll_armed);

  p_ack_word_r11: assert property (@(posedge clk) disable iff (rst)
    ack_stb |-> (rdata[DW-1] && rdata[LW-1:0] == ack_pin));

  p_idle_cmd_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && !wdata[4] && !ready) |=> ($stable(smm) && $stable(sel_isr) && !eoi_stb && $stable(rotate)));

endmodule

// File: tb/tb_pic_cmd_seq.sv
module tb_pic_cmd_seq;
  logic clk = 1'b0;
  logic rst, wr_en, rd_en, addr, best_valid;
  logic [7:0] wdata, irr, isr;
  logic [2:0] best_pin;
  logic [7:0] rdata, mask, vec_base;
  logic ack_stb, eoi_stb, eoi_spec, ready, init_err, rotate, sel_isr, poll_armed, smm, aeoi, sfnm;
  logic [2:0] ack_pin, eoi_lvl, lowprio;
  logic [7:0] s_rdata, s_mask, s_vb;
  logic s_ack, s_eoi, s_eoisp, s_rdy, s_err, s_rot, s_sel, s_poll, s_smm, s_aeoi, s_sfnm;
  logic [2:0] s_ackp, s_eoil, s_lowp;

  always #10 clk = ~clk;

  pic_cmd_seq #(.IS_MASTER(1'b1)) dut (
    .clk, .rst, .wr_en, .rd_en, .addr, .wdata, .rdata, .irr, .isr, .best_valid, .best_pin,
    .ack_stb, .ack_pin, .eoi_stb, .eoi_spec, .eoi_lvl, .ready, .init_err, .mask, .vec_base,
    .lowprio, .rotate, .sel_isr, .poll_armed, .smm, .aeoi, .sfnm);

  pic_cmd_seq #(.IS_MASTER(1'b0)) dut_s (
    .clk, .rst, .wr_en, .rd_en, .addr, .wdata, .rdata(s_rdata), .irr, .isr, .best_valid, .best_pin,
    .ack_stb(s_ack), .ack_pin(s_ackp), .eoi_stb(s_eoi), .eoi_spec(s_eoisp), .eoi_lvl(s_eoil),
    .ready(s_rdy), .init_err(s_err), .mask(s_mask), .vec_base(s_vb), .lowprio(s_lowp),
    .rotate(s_rot), .sel_isr(s_sel), .poll_armed(s_poll), .smm(s_smm), .aeoi(s_aeoi), .sfnm(s_sfnm));

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [1:0] m_step;
  logic m_ready, m_err, m_rot, m_sel, m_poll, m_smm, m_aeoi, m_sfn, m_eoi, m_eoisp;
  logic [7:0] m_mask, m_base;
  logic [2:0] m_low, m_eoil;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic a);
    if (m_poll) return best_valid ? {5'b10000, best_pin} : 8'h00;
    if (a) return m_mask;
    return m_sel ? isr : irr;
  endfunction

  task automatic model_reset();
    m_step = 0; m_ready = 0; m_err = 0; m_rot = 0; m_sel = 0; m_poll = 0; m_smm = 0;
    m_aeoi = 0; m_sfn = 0; m_eoi = 0; m_eoisp = 0; m_mask = 0; m_base = 0; m_low = 0; m_eoil = 0;
  endtask

  task automatic model_write(input logic a, input logic [7:0] d);
    m_eoi = 0;
    if (!a && d[4]) begin
      m_ready = 0; m_mask = 0; m_low = 3'd7; m_sel = 0; m_poll = 0; m_smm = 0;
      m_err = d[1] | ~d[0];
      m_step = m_err ? 2'd0 : 2'd1;
    end else if (a) begin
      if (m_step == 1) begin m_base = d & 8'hF8; m_step = 2; end
      else if (m_step == 2) m_step = 3;
      else if (m_step == 3) begin
        if (!d[0]) m_err = 1;
        else begin m_err = 0; m_aeoi = d[1]; m_sfn = d[4]; m_ready = 1; m_step = 0; end
      end else m_mask = d;
    end else if (m_ready && d[3]) begin
      if (d[6]) m_smm = d[5];
      if (d[1]) begin m_sel = d[0]; m_poll = d[2]; end
    end else if (m_ready) begin
      m_rot = d[7];
      if (d[5]) begin m_eoi = 1; m_eoisp = d[6]; m_eoil = d[2:0]; end
      if (d[6] && d[7]) m_low = d[2:0];
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "ready", {7'd0, ready}, {7'd0, m_ready});
    chk(req, "init_err", {7'd0, init_err}, {7'd0, m_err});
    chk(req, "mask", mask, m_mask);
    chk(req, "vec_base", vec_base, m_base);
    chk(req, "lowprio", {5'd0, lowprio}, {5'd0, m_low});
    chk(req, "flags", {rotate, sel_isr, poll_armed, smm, aeoi, sfnm, eoi_stb, 1'b0},
        {m_rot, m_sel, m_poll, m_smm, m_aeoi, m_sfn, m_eoi, 1'b0});
    if (m_eoi) chk(req, "eoi fields", {4'd0, eoi_spec, eoi_lvl}, {4'd0, m_eoisp, m_eoil});
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 0;
    check_all(req);
  endtask

  task automatic rd(input logic a, input logic [7:0] ir, input logic [7:0] is,
                    input logic bv, input logic [2:0] bp, input string req);
    @(negedge clk);
    rd_en = 1; addr = a; irr = ir; isr = is; best_valid = bv; best_pin = bp;
    #2;
    chk(req, "rdata", rdata, exp_read(a));
    chk(req, "ack", {4'd0, ack_stb, ack_pin & {3{ack_stb}}},
        {4'd0, m_poll & bv, bp & {3{m_poll & bv}}});
    @(posedge clk);
    m_poll = 0; m_eoi = 0;
    @(negedge clk);
    rd_en = 0;
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; irr = 0; isr = 0; best_valid = 0; best_pin = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check_all("R1");
    rd(0, 8'h5A, 8'hA5, 0, 0, "R1");
    wr(0, 8'h0B, "R12");
    wr(0, 8'h00, "R12");
    wr(0, 8'h13, "R3 single");
    wr(1, 8'h6E, "R3");
    wr(0, 8'h10, "R3 no ICW4");
    wr(1, 8'hFF, "R7");
    wr(0, 8'h11, "R2");
    wr(1, 8'h4D, "R4 ICW2");
    wr(1, 8'hFF, "R4 ICW3");
    wr(1, 8'h02, "R5");
    wr(1, 8'h13, "R6");
    chk("R6", "slave sfnm", {7'd0, s_sfnm}, 8'd0);
    chk("R6", "slave ready", {7'd0, s_rdy}, 8'd1);
    wr(1, 8'hC3, "R7");
    rd(1, 8'h00, 8'h00, 1, 5, "R10");
    wr(0, 8'h0B, "R8");
    rd(0, 8'h11, 8'h22, 0, 0, "R10");
    wr(0, 8'h68, "R8");
    wr(0, 8'h0E, "R8");
    rd(0, 8'h11, 8'h22, 1, 6, "R11");
    wr(0, 8'h04, "R8 no RR");
    wr(0, 8'h0C, "R8");
    rd(1, 8'h11, 8'h22, 0, 3, "R11 none");
    wr(0, 8'h20, "R9");
    wr(0, 8'hE5, "R9");
    wr(0, 8'hC2, "R9");
    wr(0, 8'h42, "R9");
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      if (op < 3) wr(1, d, "R7");
      else if (op < 6) begin
        if (d[4] && $urandom_range(0, 3) != 0) d[4] = 0;
        wr(0, d, "R9");
      end else if (op == 6) begin
        wr(0, 8'h11, "R2"); wr(1, d, "R4"); wr(1, 8'($urandom), "R4");
        wr(1, 8'($urandom) | 8'h01, "R6");
      end else
        rd(op[0], 8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom), "R11");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule